// File: doc/BRIEF.md
# Lock-Step Sub-Vector Offset Walker

This block produces the element offsets for a vector register move that packs or unpacks groups of sub-vector elements. A one-cycle start pulse loads a vector length and two sub-vector lengths, one for the source side and one for the destination side, plus an ordering select. The block then emits a stream of offset pairs over a ready/valid handshake. Each pair holds one source offset and one destination offset, and the downstream data mover consumes the pairs in order.

Two identical walkers run side by side, one per side. Each walker computes its offset as element index times its own sub-vector length plus the sub-element index. In the default ordering the element index is the outer loop. In the swizzle ordering the sub-element index is the outer loop, so a source length of 1 against a destination length above 1 interleaves separate vectors into one (pack), and the reverse splits them apart (unpack). Both walkers advance together on every accepted transfer. The stream stops as soon as either walker reaches its final position, and a one-cycle done pulse follows.

Top module: `zipidx_gen`

## Requirements
- R1: While reset is high and on the cycle after it, o_valid and o_done are 0.
- R2: With i_ord = 0, pair n carries, for each side with sub-length S, offset i*S+j where i = n / S and j = n % S (element index outer, sub-element inner). The first pair (0, 0) is valid on the cycle after an accepted start.
- R3: With i_ord = 1, pair n carries, for each side with sub-length S, offset i*S+j where j = n / VL and i = n % VL (sub-element outer, element index inner).
- R4: The source offset uses only the source sub-length and the destination offset uses only the destination sub-length. Both sides advance by one position on each transfer (o_valid and i_ready both high), so the n-th source offset is paired with the n-th destination offset.
- R5: Pack (source sub-length 1, destination 2 to 4) emits exactly VL pairs, with o_last high on the final one only.
- R6: Unpack (destination sub-length 1, source 2 to 4) emits exactly VL pairs, with o_last high on the final one only.
- R7: Both sub-lengths above 1 is accepted; the stream holds VL*min(source, destination) pairs.
- R8: While o_valid is high and i_ready is low, o_valid, o_src_off, o_dst_off and o_last keep their values.
- R9: A start pulse that arrives while a stream is in progress is ignored; the stream goes on unchanged with its original settings.
- R10: A start with VL = 0 emits no pair: o_valid stays 0 and o_done is high on the next cycle.
- R11: After the transfer of the last pair, o_valid is 0 and o_done is high for exactly one cycle, and the block accepts a new start.
- R12: VL = 64 with both sub-lengths 4 runs to its final offset of 255 on both sides.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| i_start | input | 1 | Start pulse, taken only when idle |
| i_ord | input | 1 | 0 = element-outer ordering, 1 = sub-element-outer ordering |
| i_vl | input | 7 | Vector length, 0 to 64 |
| i_src_sub | input | 3 | Source sub-vector length, 1 to 4 |
| i_dst_sub | input | 3 | Destination sub-vector length, 1 to 4 |
| i_ready | input | 1 | Consumer can take the current pair |
| o_valid | output | 1 | Current pair is valid |
| o_src_off | output | 8 | Source element offset |
| o_dst_off | output | 8 | Destination element offset |
| o_last | output | 1 | Current pair is the final one |
| o_done | output | 1 | One-cycle pulse when a stream has ended |

## Verification
The assertions take for granted that both sub-lengths lie between 1 and 4 and that VL does not exceed 64 whenever a start is presented, since no range check exists on those inputs. The stimulus keeps every start inside those limits, including the start pulses sent mid-stream to test that they are ignored. The expected offsets come from a closed-form model of the two orderings, with stalls inserted on selected pairs to exercise the hold rule.

// File: rtl/zipidx_pkg.sv
package zipidx_pkg;

    localparam int unsigned DEF_MAX_VL  = 64;
    localparam int unsigned DEF_MAX_SUB = 4;

    typedef enum logic {
        ORD_ELEM_OUTER = 1'b0,
        ORD_SUB_OUTER  = 1'b1
    } order_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } state_e;

endpackage

// File: rtl/zipidx_walker.sv
module zipidx_walker
    import zipidx_pkg::*;
#(
    parameter int unsigned VL_W  = 7,
    parameter int unsigned SUB_W = 3,
    parameter int unsigned OFF_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic             adv,
    input  order_e           ord,
    input  logic [VL_W-1:0]  vl,
    input  logic [SUB_W-1:0] sub,
    output logic [OFF_W-1:0] off_q,
    output logic             fin_q
);

    logic [VL_W-1:0]  i_q, i_nx;
    logic [SUB_W-1:0] j_q, j_nx;
    logic [VL_W-1:0]  vl_m1;
    logic [SUB_W-1:0] sub_m1;
    logic [OFF_W-1:0] off_nx;
    logic             fin_nx;

    assign vl_m1  = vl - VL_W'(1);
    assign sub_m1 = sub - SUB_W'(1);

    // position step for the selected loop nesting
    always_comb begin
        i_nx = i_q;
        j_nx = j_q;
        if (ord == ORD_ELEM_OUTER) begin
            if (j_q == sub_m1) begin
                j_nx = '0;
                i_nx = i_q + VL_W'(1);
            end else begin
                j_nx = j_q + SUB_W'(1);
            end
        end else begin
            if (i_q == vl_m1) begin
                i_nx = '0;
                j_nx = j_q + SUB_W'(1);
            end else begin
                i_nx = i_q + VL_W'(1);
            end
        end
        off_nx = OFF_W'(i_nx) * OFF_W'(sub) + OFF_W'(j_nx);
        fin_nx = (i_nx == vl_m1) && (j_nx == sub_m1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            i_q   <= '0;
            j_q   <= '0;
            off_q <= '0;
            fin_q <= 1'b0;
        end else if (load) begin
            i_q   <= '0;
            j_q   <= '0;
            off_q <= '0;
            fin_q <= (vl_m1 == '0) && (sub_m1 == '0);
        end else if (adv) begin
            i_q   <= i_nx;
            j_q   <= j_nx;
            off_q <= off_nx;
            fin_q <= fin_nx;
        end
    end

endmodule

// File: rtl/zipidx_gen.sv
module zipidx_gen
    import zipidx_pkg::*;
#(
    parameter int unsigned MAX_VL  = DEF_MAX_VL,
    parameter int unsigned MAX_SUB = DEF_MAX_SUB,
    localparam int unsigned VL_W   = $clog2(MAX_VL + 1),
    localparam int unsigned SUB_W  = $clog2(MAX_SUB + 1),
    localparam int unsigned OFF_W  = $clog2(MAX_VL * MAX_SUB)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             i_start,
    input  logic             i_ord,
    input  logic [VL_W-1:0]  i_vl,
    input  logic [SUB_W-1:0] i_src_sub,
    input  logic [SUB_W-1:0] i_dst_sub,
    input  logic             i_ready,
    output logic             o_valid,
    output logic [OFF_W-1:0] o_src_off,
    output logic [OFF_W-1:0] o_dst_off,
    output logic             o_last,
    output logic             o_done
);

    localparam int unsigned SIDES = 2;   // 0 = source, 1 = destination

    state_e           state_q;
    order_e           ord_q;
    logic [VL_W-1:0]  vl_q;
    logic [SUB_W-1:0] sub_q  [SIDES];
    logic [SUB_W-1:0] sub_in [SIDES];
    logic             valid_q, done_q;
    logic             busy;

    logic             accept, empty_go, fire, finish, step;
    order_e           ord_use;
    logic [VL_W-1:0]  vl_use;
    logic [OFF_W-1:0] off_w [SIDES];
    logic             fin_w [SIDES];

    assign busy     = (state_q == ST_RUN);
    assign accept   = !busy && i_start && (i_vl != '0);
    assign empty_go = !busy && i_start && (i_vl == '0);
    assign fire     = valid_q && i_ready;
    assign finish   = fire && o_last;
    assign step     = fire && !o_last;

    assign sub_in[0] = i_src_sub;
    assign sub_in[1] = i_dst_sub;

    // on the load cycle walkers see the live inputs, afterwards the latched set
    assign ord_use = accept ? order_e'(i_ord) : ord_q;
    assign vl_use  = accept ? i_vl : vl_q;

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        logic [SUB_W-1:0] sub_use;
        assign sub_use = accept ? sub_in[g] : sub_q[g];

        always_ff @(posedge clk) begin
            if (rst)         sub_q[g] <= SUB_W'(1);
            else if (accept) sub_q[g] <= sub_in[g];
        end

        zipidx_walker #(
            .VL_W  (VL_W),
            .SUB_W (SUB_W),
            .OFF_W (OFF_W)
        ) u_walk (
            .clk   (clk),
            .rst   (rst),
            .load  (accept),
            .adv   (step),
            .ord   (ord_use),
            .vl    (vl_use),
            .sub   (sub_use),
            .off_q (off_w[g]),
            .fin_q (fin_w[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ord_q   <= ORD_ELEM_OUTER;
            vl_q    <= '0;
            valid_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= empty_go || finish;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        state_q <= ST_RUN;
                        ord_q   <= order_e'(i_ord);
                        vl_q    <= i_vl;
                        valid_q <= 1'b1;
                    end
                end
                ST_RUN: begin
                    if (finish) begin
                        state_q <= ST_IDLE;
                        valid_q <= 1'b0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // stream ends once either side has reached its final position
    assign o_valid   = valid_q;
    assign o_src_off = off_w[0];
    assign o_dst_off = off_w[1];
    assign o_last    = fin_w[0] || fin_w[1];
    assign o_done    = done_q;

endmodule

// File: rtl/zipidx_chk.sv
module zipidx_chk #(
    parameter int unsigned VL_W  = 7,
    parameter int unsigned OFF_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [VL_W-1:0]  vl,
    input logic             ready,
    input logic             valid,
    input logic [OFF_W-1:0] src_off,
    input logic [OFF_W-1:0] dst_off,
    input logic             last,
    input logic             done,
    input logic             busy
);

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (!valid && !done));

    a_r2_first_pair_zero: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && vl != '0) |=> (valid && src_off == '0 && dst_off == '0));

    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(src_off) && $stable(dst_off) && $stable(last)));

    a_r10_empty_run: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && vl == '0) |=> (done && !valid));

    a_r11_done_after_last: assert property (@(posedge clk) disable iff (rst)
        (valid && ready && last) |=> (done && !valid));

    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !valid);

endmodule

bind zipidx_gen zipidx_chk #(
    .VL_W  (VL_W),
    .OFF_W (OFF_W)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (i_start),
    .vl      (i_vl),
    .ready   (i_ready),
    .valid   (o_valid),
    .src_off (o_src_off),
    .dst_off (o_dst_off),
    .last    (o_last),
    .done    (o_done),
    .busy    (busy)
);

// File: tb/sim_zipidx_gen.sv
`timescale 1ns/1ps
module sim_zipidx_gen;

    localparam time CYC = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       i_start = 1'b0;
    logic       i_ord = 1'b0;
    logic [6:0] i_vl = '0;
    logic [2:0] i_src_sub = 3'd1;
    logic [2:0] i_dst_sub = 3'd1;
    logic       i_ready = 1'b0;
    logic       o_valid, o_last, o_done;
    logic [7:0] o_src_off, o_dst_off;

    int n_chk = 0;
    int n_bad = 0;

    always #(CYC/2) clk = ~clk;

    zipidx_gen u0 (
        .clk(clk), .rst(rst), .i_start(i_start), .i_ord(i_ord), .i_vl(i_vl),
        .i_src_sub(i_src_sub), .i_dst_sub(i_dst_sub), .i_ready(i_ready),
        .o_valid(o_valid), .o_src_off(o_src_off), .o_dst_off(o_dst_off),
        .o_last(o_last), .o_done(o_done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_off(input bit ord, input int vl, input int sub, input int n);
        int i, j;
        if (!ord) begin
            i = n / sub; j = n % sub;
        end else begin
            j = n / vl;  i = n % vl;
        end
        return i * sub + j;
    endfunction

    // entry: {req[3:0], ign, stall, ord, vl[6:0], src[2:0], dst[2:0]}
    localparam int NV = 10;
    localparam logic [19:0] VEC [NV] = '{
        {4'd2,  1'b0, 1'b0, 1'b0, 7'd3,  3'd1, 3'd1},  // R2 plain element-outer
        {4'd7,  1'b0, 1'b0, 1'b0, 7'd4,  3'd2, 3'd3},  // R7 both above one
        {4'd5,  1'b0, 1'b0, 1'b1, 7'd3,  3'd1, 3'd4},  // R5 pack
        {4'd6,  1'b0, 1'b0, 1'b1, 7'd4,  3'd3, 3'd1},  // R6 unpack
        {4'd3,  1'b0, 1'b0, 1'b1, 7'd3,  3'd2, 3'd2},  // R3 sub-element-outer
        {4'd8,  1'b0, 1'b1, 1'b0, 7'd5,  3'd4, 3'd4},  // R8 stalls
        {4'd9,  1'b1, 1'b0, 1'b1, 7'd2,  3'd4, 3'd3},  // R9 start mid-stream
        {4'd11, 1'b0, 1'b0, 1'b0, 7'd1,  3'd1, 3'd1},  // R11 single pair
        {4'd12, 1'b0, 1'b1, 1'b1, 7'd64, 3'd4, 3'd4},  // R12 largest
        {4'd4,  1'b0, 1'b0, 1'b0, 7'd5,  3'd1, 3'd3}   // R4 separate lengths
    };

    task automatic run_vec(input logic [19:0] v);
        int rq, vl, ss, ds, np;
        bit ign, stall, ord;
        string tag;
        rq = int'(v[19:16]); ign = v[15]; stall = v[14]; ord = v[13];
        vl = int'(v[12:6]); ss = int'(v[5:3]); ds = int'(v[2:0]);
        np = vl * ((ss < ds) ? ss : ds);
        tag = $sformatf("R%0d", rq);
        i_ord = ord; i_vl = 7'(vl); i_src_sub = 3'(ss); i_dst_sub = 3'(ds);
        i_start = 1'b1; i_ready = 1'b0;
        @(negedge clk);
        i_start = 1'b0;
        for (int n = 0; n < np; n++) begin
            int es, ed;
            es = exp_off(ord, vl, ss, n);
            ed = exp_off(ord, vl, ds, n);
            chk(o_valid == 1'b1, tag, int'(o_valid), 1);
            chk(int'(o_src_off) == es, tag, int'(o_src_off), es);
            chk(int'(o_dst_off) == ed, tag, int'(o_dst_off), ed);
            chk(o_last == (n == np - 1), tag, int'(o_last), int'(n == np - 1));
            if (stall && (n % 2 == 1)) begin
                i_ready = 1'b0;
                @(negedge clk);
                // R8: pair held under back-pressure
                chk(o_valid && int'(o_src_off) == es && int'(o_dst_off) == ed,
                    "R8", int'(o_src_off), es);
            end
            if (ign && n == 1) begin
                // R9: this start must leave the stream untouched
                i_start = 1'b1; i_vl = 7'd9; i_src_sub = 3'd1; i_dst_sub = 3'd1; i_ord = ~ord;
            end
            i_ready = 1'b1;
            @(negedge clk);
            i_start = 1'b0;
        end
        i_ready = 1'b0;
        // R11: done pulse right after last transfer
        chk(o_done == 1'b1 && o_valid == 1'b0, "R11", int'(o_done), 1);
        @(negedge clk);
        chk(o_done == 1'b0, "R11", int'(o_done), 0);
    endtask

    initial begin
        #(CYC * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: quiet during reset
        chk(o_valid == 1'b0 && o_done == 1'b0, "R1", int'(o_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(o_valid == 1'b0 && o_done == 1'b0, "R1", int'(o_done), 0);

        for (int k = 0; k < NV; k++) run_vec(VEC[k]);

        // R10: zero-length start
        i_vl = 7'd0; i_src_sub = 3'd2; i_dst_sub = 3'd3; i_start = 1'b1;
        @(negedge clk);
        i_start = 1'b0;
        chk(o_done == 1'b1, "R10", int'(o_done), 1);
        chk(o_valid == 1'b0, "R10", int'(o_valid), 0);
        @(negedge clk);
        chk(o_done == 1'b0 && o_valid == 1'b0, "R10", int'(o_valid), 0);

        // R11: block accepts a fresh start after an empty run
        run_vec({4'd11, 1'b0, 1'b0, 1'b1, 7'd2, 3'd2, 3'd1});

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule